// File: doc/BRIEF.md
# Surface copy path selector

This unit decides how a rectangular surface copy is carried out. Each request gives a source and a destination surface descriptor. A descriptor holds the row pitch (zero marks a swizzled layout), the width, height and depth, the bytes per pixel and the corner coordinates of the rectangle. The destination descriptor also carries the byte offset and a local-memory flag. A separate input says whether the newer 3D engine generation is fitted. Four eligibility tests run in parallel, one for each copy engine. A fixed-priority pick then names one engine, or raises an error when no engine can take the copy.

The decision is registered. One clock after a valid strobe, the unit presents a one-hot engine choice or the error bit, together with a one-cycle result-valid pulse. The choice is held until the next strobe. The caller uses the choice to build the command stream for that engine. The unit itself issues no commands and moves no data.

Top module: `copy_path_sel`

## Requirements
- R1: A copy is scaled when (src_x1-src_x0) differs from (dst_x1-dst_x0), or (src_y1-src_y0) differs from (dst_y1-dst_y0).
- R2: The memory-copy engine (sel_o bit 0) is eligible only when both pitches are nonzero and the copy is not scaled.
- R3: The scaled-image engine (sel_o bit 1) is eligible only when all of these hold: the source pitch is nonzero, the source width and height are each within 2..1024, and the depth of each surface is at most 1.
- R4: For the scaled-image engine, dst_ofs_i must also be a multiple of 64. A destination with zero pitch must have width and height within 2..2048. A destination with nonzero pitch must have dst_vram_i=1 and a pitch that is a multiple of 64.
- R5: The 3D blit engine (sel_o bit 2) is eligible only when all of these hold: gen_new_i=1, the destination offset and pitch are multiples of 64, the destination depth is at most 1, and the destination width and height are each at least 2.
- R6: The 3D blit engine is not eligible when either surface has more than 4 bytes per pixel, or when the destination has 1 byte per pixel and zero pitch.
- R7: The software fallback (sel_o bit 3) is eligible whenever the copy is not scaled.
- R8: When several engines are eligible, the choice follows the order memory-copy, scaled-image, 3D blit, fallback.
- R9: When no engine is eligible, err_o=1 and sel_o=0.
- R10: sel_o, err_o and vld_o update on the first rising clock edge after valid_i=1, and vld_o pulses for that one cycle. Each result has exactly one bit set among sel_o and err_o. While valid_i=0, sel_o and err_o hold.
- R11: While rst_ni=0, sel_o=0, err_o=0 and vld_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| gen_new_i | input | 1 | Newer 3D engine generation present |
| src_pitch_i | input | PITCH_W | Source row pitch, 0 = swizzled |
| src_w_i | input | DIM_W | Source width |
| src_h_i | input | DIM_W | Source height |
| src_d_i | input | DEP_W | Source depth |
| src_bpp_i | input | BPP_W | Source bytes per pixel |
| src_x0_i | input | CRD_W | Source left edge |
| src_x1_i | input | CRD_W | Source right edge |
| src_y0_i | input | CRD_W | Source top edge |
| src_y1_i | input | CRD_W | Source bottom edge |
| dst_ofs_i | input | OFS_W | Destination byte offset |
| dst_pitch_i | input | PITCH_W | Destination row pitch, 0 = swizzled |
| dst_w_i | input | DIM_W | Destination width |
| dst_h_i | input | DIM_W | Destination height |
| dst_d_i | input | DEP_W | Destination depth |
| dst_bpp_i | input | BPP_W | Destination bytes per pixel |
| dst_vram_i | input | 1 | Destination in local video memory |
| dst_x0_i | input | CRD_W | Destination left edge |
| dst_x1_i | input | CRD_W | Destination right edge |
| dst_y0_i | input | CRD_W | Destination top edge |
| dst_y1_i | input | CRD_W | Destination bottom edge |
| sel_o | output | 4 | One-hot engine choice |
| err_o | output | 1 | No engine eligible |
| vld_o | output | 1 | Result valid pulse |

## Verification
The hardest outcome to reach from the ports is the error result. It needs a scaled copy that all three hardware engines reject for different reasons at the same time. Random descriptors seldom produce it, because most settings leave the fallback or the blit path open. The stimulus therefore starts from a linear, aligned baseline. Each directed case breaks exactly one rule, such as an offset of 32, a pitch of 96, an old engine generation, an 8-byte source pixel or a swizzled 1-byte destination, on top of a scaling that already rules out the memory-copy engine and the fallback. A behavioural model then checks the outputs on every clock while biased random descriptors sit close to each bound.

// File: rtl/copy_sel_pkg.sv
package copy_sel_pkg;
  localparam int NUM_ENG = 4;
  typedef enum logic [1:0] {
    ENG_MEM  = 2'd0,
    ENG_IMG  = 2'd1,
    ENG_BLIT = 2'd2,
    ENG_SW   = 2'd3
  } eng_e;
endpackage

// File: rtl/copy_extent_cmp.sv
module copy_extent_cmp #(
  parameter int CRD_W = 14
) (
  input  logic [CRD_W-1:0] src_x0_i,
  input  logic [CRD_W-1:0] src_x1_i,
  input  logic [CRD_W-1:0] src_y0_i,
  input  logic [CRD_W-1:0] src_y1_i,
  input  logic [CRD_W-1:0] dst_x0_i,
  input  logic [CRD_W-1:0] dst_x1_i,
  input  logic [CRD_W-1:0] dst_y0_i,
  input  logic [CRD_W-1:0] dst_y1_i,
  output logic             scaled_o
);
  logic [CRD_W-1:0] src_ext_x, src_ext_y, dst_ext_x, dst_ext_y;

  always_comb begin
    src_ext_x = src_x1_i - src_x0_i;
    src_ext_y = src_y1_i - src_y0_i;
    dst_ext_x = dst_x1_i - dst_x0_i;
    dst_ext_y = dst_y1_i - dst_y0_i;
    scaled_o  = (src_ext_x != dst_ext_x) || (src_ext_y != dst_ext_y);
  end
endmodule

// File: rtl/copy_elig_chk.sv
module copy_elig_chk
  import copy_sel_pkg::*;
#(
  parameter int OFS_W       = 32,
  parameter int PITCH_W     = 16,
  parameter int DIM_W       = 13,
  parameter int DEP_W       = 12,
  parameter int BPP_W       = 4,
  parameter int ALIGN_LG    = 6,
  parameter int MIN_DIM     = 2,
  parameter int IMG_SRC_MAX = 1024,
  parameter int IMG_DST_MAX = 2048,
  parameter int BPP_MAX     = 4
) (
  input  logic               gen_new_i,
  input  logic               scaled_i,
  input  logic [PITCH_W-1:0] src_pitch_i,
  input  logic [DIM_W-1:0]   src_w_i,
  input  logic [DIM_W-1:0]   src_h_i,
  input  logic [DEP_W-1:0]   src_d_i,
  input  logic [BPP_W-1:0]   src_bpp_i,
  input  logic [OFS_W-1:0]   dst_ofs_i,
  input  logic [PITCH_W-1:0] dst_pitch_i,
  input  logic [DIM_W-1:0]   dst_w_i,
  input  logic [DIM_W-1:0]   dst_h_i,
  input  logic [DEP_W-1:0]   dst_d_i,
  input  logic [BPP_W-1:0]   dst_bpp_i,
  input  logic               dst_vram_i,
  output logic [NUM_ENG-1:0] elig_o
);
  localparam logic [DIM_W-1:0] DIM_LO  = DIM_W'(MIN_DIM);
  localparam logic [DIM_W-1:0] SRC_HI  = DIM_W'(IMG_SRC_MAX);
  localparam logic [DIM_W-1:0] DST_HI  = DIM_W'(IMG_DST_MAX);
  localparam logic [DEP_W-1:0] DEP_ONE = DEP_W'(1);
  localparam logic [BPP_W-1:0] BPP_HI  = BPP_W'(BPP_MAX);
  localparam logic [BPP_W-1:0] BPP_ONE = BPP_W'(1);

  logic src_lin, dst_lin, ofs_al, pitch_al, flat;
  logic src_fit, dst_swz_fit, dst_lin_ok;

  always_comb begin
    src_lin     = src_pitch_i != '0;
    dst_lin     = dst_pitch_i != '0;
    ofs_al      = dst_ofs_i[ALIGN_LG-1:0] == '0;
    pitch_al    = dst_pitch_i[ALIGN_LG-1:0] == '0;
    flat        = (src_d_i <= DEP_ONE) && (dst_d_i <= DEP_ONE);
    src_fit     = (src_w_i >= DIM_LO) && (src_w_i <= SRC_HI) &&
                  (src_h_i >= DIM_LO) && (src_h_i <= SRC_HI);
    dst_swz_fit = (dst_w_i >= DIM_LO) && (dst_w_i <= DST_HI) &&
                  (dst_h_i >= DIM_LO) && (dst_h_i <= DST_HI);
    dst_lin_ok  = dst_vram_i && pitch_al;

    elig_o[ENG_MEM] = src_lin && dst_lin && !scaled_i;
    elig_o[ENG_IMG] = src_lin && src_fit && flat && ofs_al &&
                      (dst_lin ? dst_lin_ok : dst_swz_fit);
    elig_o[ENG_BLIT] = gen_new_i && ofs_al && pitch_al &&
                       (dst_d_i <= DEP_ONE) &&
                       (dst_w_i >= DIM_LO) && (dst_h_i >= DIM_LO) &&
                       (dst_bpp_i <= BPP_HI) && (src_bpp_i <= BPP_HI) &&
                       !((dst_bpp_i == BPP_ONE) && !dst_lin);
    elig_o[ENG_SW] = !scaled_i;
  end
endmodule

// File: rtl/copy_prio_enc.sv
module copy_prio_enc #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         none_o
);
  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt_o[i] = req_i[i] && !taken;
      taken    = taken || req_i[i];
    end
    none_o = !taken;
  end
endmodule

// File: rtl/copy_path_sel.sv
module copy_path_sel
  import copy_sel_pkg::*;
#(
  parameter int OFS_W       = 32,
  parameter int PITCH_W     = 16,
  parameter int DIM_W       = 13,
  parameter int DEP_W       = 12,
  parameter int BPP_W       = 4,
  parameter int CRD_W       = 14,
  parameter int ALIGN_LG    = 6,
  parameter int MIN_DIM     = 2,
  parameter int IMG_SRC_MAX = 1024,
  parameter int IMG_DST_MAX = 2048,
  parameter int BPP_MAX     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               gen_new_i,
  input  logic [PITCH_W-1:0] src_pitch_i,
  input  logic [DIM_W-1:0]   src_w_i,
  input  logic [DIM_W-1:0]   src_h_i,
  input  logic [DEP_W-1:0]   src_d_i,
  input  logic [BPP_W-1:0]   src_bpp_i,
  input  logic [CRD_W-1:0]   src_x0_i,
  input  logic [CRD_W-1:0]   src_x1_i,
  input  logic [CRD_W-1:0]   src_y0_i,
  input  logic [CRD_W-1:0]   src_y1_i,
  input  logic [OFS_W-1:0]   dst_ofs_i,
  input  logic [PITCH_W-1:0] dst_pitch_i,
  input  logic [DIM_W-1:0]   dst_w_i,
  input  logic [DIM_W-1:0]   dst_h_i,
  input  logic [DEP_W-1:0]   dst_d_i,
  input  logic [BPP_W-1:0]   dst_bpp_i,
  input  logic               dst_vram_i,
  input  logic [CRD_W-1:0]   dst_x0_i,
  input  logic [CRD_W-1:0]   dst_x1_i,
  input  logic [CRD_W-1:0]   dst_y0_i,
  input  logic [CRD_W-1:0]   dst_y1_i,
  output logic [NUM_ENG-1:0] sel_o,
  output logic               err_o,
  output logic               vld_o
);
  logic               scaled;
  logic [NUM_ENG-1:0] elig, gnt;
  logic               none;

  copy_extent_cmp #(.CRD_W(CRD_W)) u_ext (
    .src_x0_i(src_x0_i), .src_x1_i(src_x1_i),
    .src_y0_i(src_y0_i), .src_y1_i(src_y1_i),
    .dst_x0_i(dst_x0_i), .dst_x1_i(dst_x1_i),
    .dst_y0_i(dst_y0_i), .dst_y1_i(dst_y1_i),
    .scaled_o(scaled)
  );

  copy_elig_chk #(
    .OFS_W(OFS_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W), .DEP_W(DEP_W),
    .BPP_W(BPP_W), .ALIGN_LG(ALIGN_LG), .MIN_DIM(MIN_DIM),
    .IMG_SRC_MAX(IMG_SRC_MAX), .IMG_DST_MAX(IMG_DST_MAX), .BPP_MAX(BPP_MAX)
  ) u_elig (
    .gen_new_i(gen_new_i), .scaled_i(scaled),
    .src_pitch_i(src_pitch_i), .src_w_i(src_w_i), .src_h_i(src_h_i),
    .src_d_i(src_d_i), .src_bpp_i(src_bpp_i),
    .dst_ofs_i(dst_ofs_i), .dst_pitch_i(dst_pitch_i), .dst_w_i(dst_w_i),
    .dst_h_i(dst_h_i), .dst_d_i(dst_d_i), .dst_bpp_i(dst_bpp_i),
    .dst_vram_i(dst_vram_i),
    .elig_o(elig)
  );

  copy_prio_enc #(.N(NUM_ENG)) u_prio (
    .req_i(elig), .gnt_o(gnt), .none_o(none)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= '0;
      err_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        sel_o <= gnt;
        err_o <= none;
      end
    end
  end
endmodule

// File: rtl/copy_path_sel_chk.sv
module copy_path_sel_chk #(
  parameter int PITCH_W = 16,
  parameter int CRD_W   = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               gen_new_i,
  input logic [PITCH_W-1:0] src_pitch_i,
  input logic [PITCH_W-1:0] dst_pitch_i,
  input logic [CRD_W-1:0]   src_x0_i,
  input logic [CRD_W-1:0]   src_x1_i,
  input logic [CRD_W-1:0]   src_y0_i,
  input logic [CRD_W-1:0]   src_y1_i,
  input logic [CRD_W-1:0]   dst_x0_i,
  input logic [CRD_W-1:0]   dst_x1_i,
  input logic [CRD_W-1:0]   dst_y0_i,
  input logic [CRD_W-1:0]   dst_y1_i,
  input logic [3:0]         sel_o,
  input logic               err_o,
  input logic               vld_o
);
  logic same_ext;
  assign same_ext = ((src_x1_i - src_x0_i) == (dst_x1_i - dst_x0_i)) &&
                    ((src_y1_i - src_y0_i) == (dst_y1_i - dst_y0_i));

  assert_result_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $countones({sel_o, err_o}) == 1);

  assert_vld_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> vld_o);

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!vld_o && $stable(sel_o) && $stable(err_o)));

  assert_fallback_no_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && same_ext) |=> !err_o);

  assert_memcopy_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && same_ext && src_pitch_i != '0 && dst_pitch_i != '0) |=> sel_o[0]);

  assert_blit_gen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !gen_new_i) |=> !sel_o[2]);
endmodule

bind copy_path_sel copy_path_sel_chk #(.PITCH_W(PITCH_W), .CRD_W(CRD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .gen_new_i(gen_new_i),
  .src_pitch_i(src_pitch_i), .dst_pitch_i(dst_pitch_i),
  .src_x0_i(src_x0_i), .src_x1_i(src_x1_i), .src_y0_i(src_y0_i), .src_y1_i(src_y1_i),
  .dst_x0_i(dst_x0_i), .dst_x1_i(dst_x1_i), .dst_y0_i(dst_y0_i), .dst_y1_i(dst_y1_i),
  .sel_o(sel_o), .err_o(err_o), .vld_o(vld_o)
);

// File: tb/sim_copy_path_sel.sv
module sim_copy_path_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        gen_new;
  logic [15:0] src_pitch, dst_pitch;
  logic [12:0] src_w, src_h, dst_w, dst_h;
  logic [11:0] src_d, dst_d;
  logic [3:0]  src_bpp, dst_bpp;
  logic [31:0] dst_ofs;
  logic        dst_vram;
  logic [13:0] sx0, sx1, sy0, sy1, dx0, dx1, dy0, dy1;
  logic [3:0]  sel;
  logic        err, vld;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R11";

  logic [3:0] exp_sel;
  logic       exp_err, exp_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  copy_path_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .gen_new_i(gen_new),
    .src_pitch_i(src_pitch), .src_w_i(src_w), .src_h_i(src_h), .src_d_i(src_d),
    .src_bpp_i(src_bpp), .src_x0_i(sx0), .src_x1_i(sx1), .src_y0_i(sy0),
    .src_y1_i(sy1), .dst_ofs_i(dst_ofs), .dst_pitch_i(dst_pitch),
    .dst_w_i(dst_w), .dst_h_i(dst_h), .dst_d_i(dst_d), .dst_bpp_i(dst_bpp),
    .dst_vram_i(dst_vram), .dst_x0_i(dx0), .dst_x1_i(dx1), .dst_y0_i(dy0),
    .dst_y1_i(dy1), .sel_o(sel), .err_o(err), .vld_o(vld)
  );

  // behavioural reference: 0 mem, 1 img, 2 blit, 3 fallback, 4 error
  function automatic int ref_pick();
    bit scaled, mem_ok, img_ok, blit_ok;
    int sew, seh, dew, deh;
    sew = int'(sx1) - int'(sx0); seh = int'(sy1) - int'(sy0);
    dew = int'(dx1) - int'(dx0); deh = int'(dy1) - int'(dy0);
    scaled = (sew != dew) || (seh != deh);
    mem_ok = (src_pitch != 0) && (dst_pitch != 0) && !scaled;
    img_ok = (src_pitch != 0) && src_w >= 2 && src_w <= 1024 &&
             src_h >= 2 && src_h <= 1024 && src_d <= 1 && dst_d <= 1 &&
             (dst_ofs % 64 == 0);
    if (dst_pitch == 0)
      img_ok = img_ok && dst_w >= 2 && dst_w <= 2048 && dst_h >= 2 && dst_h <= 2048;
    else
      img_ok = img_ok && dst_vram && (dst_pitch % 64 == 0);
    blit_ok = gen_new && (dst_ofs % 64 == 0) && (dst_pitch % 64 == 0) &&
              dst_d <= 1 && dst_w >= 2 && dst_h >= 2 && dst_bpp <= 4 &&
              src_bpp <= 4 && !(dst_bpp == 1 && dst_pitch == 0);
    if (mem_ok) return 0;
    if (img_ok) return 1;
    if (blit_ok) return 2;
    if (!scaled) return 3;
    return 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_sel <= '0; exp_err <= 1'b0; exp_vld <= 1'b0;
    end else begin
      exp_vld <= valid;
      if (valid) begin
        int k;
        k = ref_pick();
        exp_sel <= (k < 4) ? 4'(1 << k) : 4'd0;
        exp_err <= (k == 4);
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (sel !== exp_sel || err !== exp_err || vld !== exp_vld) begin
        n_fail++;
        $display("FAIL %s: sel=%b err=%b vld=%b expected sel=%b err=%b vld=%b",
                 cur_req, sel, err, vld, exp_sel, exp_err, exp_vld);
      end
    end
  end

  task automatic set_base();
    gen_new = 1; src_pitch = 256; dst_pitch = 256;
    src_w = 64; src_h = 64; dst_w = 64; dst_h = 64;
    src_d = 1; dst_d = 1; src_bpp = 4; dst_bpp = 4;
    dst_ofs = 0; dst_vram = 1;
    sx0 = 4; sx1 = 12; sy0 = 4; sy1 = 12;
    dx0 = 0; dx1 = 8;  dy0 = 0; dy1 = 8;
  endtask

  // inputs set at a negedge; result sampled one negedge later
  task automatic run(string tag, int exp_k);
    logic [3:0] es;
    cur_req = tag;
    valid = 1;
    @(negedge clk);
    valid = 0;
    es = (exp_k < 4) ? 4'(1 << exp_k) : 4'd0;
    n_tests++;
    if (sel !== es || err !== (exp_k == 4) || vld !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: sel=%b err=%b vld=%b expected sel=%b err=%b vld=1",
               tag, sel, err, vld, es, exp_k == 4);
    end
    @(negedge clk);
  endtask

  task automatic scale_x();
    dx1 = dx1 + 1;
  endtask

  initial begin
    set_base();
    repeat (3) @(negedge clk);
    cur_req = "R11";
    n_tests++;
    if (sel !== 0 || err !== 0 || vld !== 0) begin
      n_fail++;
      $display("FAIL R11: sel=%b err=%b vld=%b expected 0 0 0", sel, err, vld);
    end
    rst_n = 1;
    @(negedge clk);

    set_base(); run("R2", 0);
    set_base(); src_pitch = 0; run("R2", 2);
    set_base(); scale_x(); run("R1", 1);
    set_base(); dy1 = dy1 + 2; run("R1", 1);
    set_base(); scale_x(); src_w = 1025; run("R3", 2);
    set_base(); scale_x(); src_w = 1024; run("R3", 1);
    set_base(); scale_x(); src_h = 1; run("R3", 2);
    set_base(); scale_x(); src_d = 2; run("R3", 2);
    set_base(); scale_x(); dst_ofs = 32; run("R4", 4);
    set_base(); scale_x(); dst_vram = 0; run("R4", 2);
    set_base(); scale_x(); dst_pitch = 96; run("R4", 4);
    set_base(); scale_x(); dst_pitch = 0; dst_w = 4096; run("R4", 2);
    set_base(); scale_x(); dst_pitch = 0; dst_w = 2048; run("R4", 1);
    set_base(); scale_x(); src_pitch = 0; gen_new = 0; run("R5", 4);
    set_base(); scale_x(); src_pitch = 0; dst_d = 2; run("R5", 4);
    set_base(); scale_x(); src_pitch = 0; dst_w = 1; run("R5", 4);
    set_base(); scale_x(); src_pitch = 0; dst_ofs = 64; run("R5", 2);
    set_base(); scale_x(); src_pitch = 0; src_bpp = 8; run("R6", 4);
    set_base(); scale_x(); src_pitch = 0; dst_bpp = 5; run("R6", 4);
    set_base(); scale_x(); src_pitch = 0; dst_pitch = 0; dst_bpp = 1; run("R6", 4);
    set_base(); scale_x(); src_pitch = 0; dst_bpp = 1; run("R6", 2);
    set_base(); src_pitch = 0; gen_new = 0; run("R7", 3);
    set_base(); dst_pitch = 0; gen_new = 0; dst_bpp = 1; run("R7", 1);
    set_base(); src_pitch = 0; gen_new = 1; run("R8", 2);
    set_base(); scale_x(); run("R8", 1);
    set_base(); scale_x(); src_pitch = 0; gen_new = 0; run("R9", 4);

    // idle cycles: outputs must hold (checked every clock by the model)
    cur_req = "R10";
    set_base(); src_pitch = 0; scale_x(); gen_new = 0;
    repeat (4) @(negedge clk);

    cur_req = "R8";
    for (int i = 0; i < 600; i++) begin
      set_base();
      gen_new   = 1'($urandom_range(0, 3) != 0);
      src_pitch = ($urandom_range(0, 2) == 0) ? 16'd0 : 16'($urandom_range(1, 8) * 32);
      dst_pitch = ($urandom_range(0, 2) == 0) ? 16'd0 : 16'($urandom_range(1, 8) * 32);
      src_w     = 13'($urandom_range(0, 1030));
      src_h     = 13'($urandom_range(0, 1030));
      dst_w     = 13'($urandom_range(0, 2060));
      dst_h     = 13'($urandom_range(0, 2060));
      src_d     = 12'($urandom_range(0, 2));
      dst_d     = 12'($urandom_range(0, 2));
      src_bpp   = 4'($urandom_range(1, 8));
      dst_bpp   = 4'($urandom_range(1, 5));
      dst_ofs   = 32'($urandom_range(0, 7) * 32);
      dst_vram  = 1'($urandom_range(0, 1));
      sx0 = 14'($urandom_range(0, 50)); sx1 = sx0 + 14'($urandom_range(0, 3));
      sy0 = 14'($urandom_range(0, 50)); sy1 = sy0 + 14'($urandom_range(0, 3));
      dx0 = 14'($urandom_range(0, 50)); dx1 = dx0 + 14'($urandom_range(0, 3));
      dy0 = 14'($urandom_range(0, 50)); dy1 = dy0 + 14'($urandom_range(0, 3));
      valid = 1'($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    valid = 0;
    @(negedge clk);
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule